// File: doc/BRIEF.md
# Parallel-to-Serial Word Serializer with Exported Word Clock

This block turns a 16-bit parallel word into a continuous serial bit stream. It runs from a single high-speed bit clock and takes all of its internal timing from the falling edge of that clock. From the bit clock it derives a word clock at one sixteenth of the bit rate, with eight bit periods high and eight low. The word clock is driven out so that the upstream data source can be clocked by it and stay aligned with the serializer.

The parallel word is sampled once per word period, at the bit-clock edge where the word clock falls. A source that updates on the rising edge of the word clock therefore has half a word period of setup and half of hold. The sampled word is held in a shadow register. At the word boundary, where the word clock rises, it is loaded into the shift register, which then sends one bit per bit-clock cycle with the least significant bit first. Successive words follow one another with no idle bit between them.

Top module: `word_serializer`

## Requirements
- R1: `word_clk` has a period of 16 bit-clock cycles, 8 high and 8 low. Counting falling edges of `bit_clk` from the first one after reset is released (edge 1), `word_clk` is high after edge n when n mod 16 is 0 to 7 and low when it is 8 to 15.
- R2: `ser_out` and `word_clk` change only at falling edges of `bit_clk`. Between a rising edge and the next falling edge they hold their value.
- R3: `par_data` is sampled only at the falling edge of `bit_clk` where `word_clk` goes from high to low (edge 8 + 16k). A change of `par_data` at any other time has no effect on the serial stream.
- R4: Within a word, bit 0 is sent first and bit 15 last, one bit per bit-clock cycle.
- R5: A word sampled at edge 8 + 16k appears at `ser_out` as bit 0 after edge 16 + 16k, 8 bit-clock cycles later, at the rising edge of `word_clk`. Bit i is on `ser_out` after edge 16 + 16k + i.
- R6: `rst` is synchronous and active high, and is sampled at falling edges of `bit_clk`. At each such edge it clears the divider and the shift register: `ser_out` goes low and `word_clk` goes high. After release, `ser_out` stays low for the first 15 bit-clock cycles, until the first word is loaded.
- R7: Consecutive words are sent back to back. Bit 15 of one word is followed directly by bit 0 of the next, with no bit dropped or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | High-speed bit clock; the falling edge is active |
| rst | input | 1 | Synchronous reset, active high |
| par_data | input | 16 | Parallel word from the source |
| ser_out | output | 1 | Serial data, bit 0 of each word first |
| word_clk | output | 1 | Bit clock divided by 16, 8 high / 8 low |

## Verification
The assertions check on every falling edge that:
- the divider phase steps by one;
- the word clock toggles only at the half-period and word boundaries;
- the shadow register changes only on the capture strobe;
- each serial bit is either the next bit of the shift register or bit 0 of the shadow word at a load;
- the state is cleared on the first edge after reset.

Only the bench scenarios can show the end-to-end mapping from a parallel word to its 16 serial bits. The same holds for the 8-cycle latency, for data changes before or after the capture edge being used or ignored, and for the stream restarting after a reset in the middle of a word.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;

  // Phase that follows c in a divider of the given period.
  function automatic int next_phase(input int c, input int period);
    return (c == period - 1) ? 0 : c + 1;
  endfunction

  // Word clock level for a given divider phase: high in the first half.
  function automatic logic high_half(input int c, input int period);
    return (c < period / 2);
  endfunction

endpackage

// File: rtl/ser_divider.sv
`timescale 1ns/1ps
module ser_divider
  import ser_pkg::*;
#(
  parameter int RATIO = 16,
  localparam int CW = $clog2(RATIO)
) (
  input  logic clk,
  input  logic rst,
  output logic word_clk,
  output logic cap_evt,
  output logic load_evt
);

  logic [CW-1:0] phase;
  logic [CW-1:0] phase_nxt;

  always_comb phase_nxt = CW'(next_phase(int'(phase), RATIO));

  always_ff @(negedge clk) begin
    if (rst) begin
      phase    <= '0;
      word_clk <= 1'b1;
    end else begin
      phase    <= phase_nxt;
      word_clk <= high_half(int'(phase_nxt), RATIO);
    end
  end

  // Capture where word_clk falls; load where it rises.
  assign cap_evt  = (phase == CW'(RATIO / 2 - 1));
  assign load_evt = (phase == CW'(RATIO - 1));

  // R1
  phase_step_chk: assert property (@(negedge clk) disable iff (rst)
    !$past(rst) |-> phase == CW'(next_phase(int'($past(phase)), RATIO)));

  // R1
  wclk_toggle_chk: assert property (@(negedge clk) disable iff (rst)
    !$past(rst) |-> ((word_clk != $past(word_clk)) ==
                     ($past(phase) == CW'(RATIO / 2 - 1) || $past(phase) == CW'(RATIO - 1))));

  // R6
  div_reset_chk: assert property (@(negedge clk) disable iff (rst)
    $past(rst) |-> (phase == '0 && word_clk));

endmodule

// File: rtl/ser_capture.sv
`timescale 1ns/1ps
module ser_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_evt,
  input  logic [W-1:0] din,
  output logic [W-1:0] shadow
);

  always_ff @(negedge clk) begin
    if (rst)          shadow <= '0;
    else if (cap_evt) shadow <= din;
  end

  // R3
  shadow_hold_chk: assert property (@(negedge clk) disable iff (rst)
    (!$past(rst) && !$past(cap_evt)) |-> $stable(shadow));

endmodule

// File: rtl/ser_shifter.sv
`timescale 1ns/1ps
module ser_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_evt,
  input  logic [W-1:0] shadow,
  output logic         ser_out
);

  logic [W-1:0] sh_q;

  always_ff @(negedge clk) begin
    if (rst)           sh_q <= '0;
    else if (load_evt) sh_q <= shadow;
    else               sh_q <= {1'b0, sh_q[W-1:1]};
  end

  assign ser_out = sh_q[0];

  // R4
  shift_order_chk: assert property (@(negedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_evt)) |-> ser_out == $past(sh_q[1]));

  // R5
  load_first_chk: assert property (@(negedge clk) disable iff (rst)
    (!$past(rst) && $past(load_evt)) |-> ser_out == $past(shadow[0]));

  // R6
  ser_reset_chk: assert property (@(negedge clk) disable iff (rst)
    $past(rst) |-> !ser_out);

endmodule

// File: rtl/word_serializer.sv
`timescale 1ns/1ps
module word_serializer #(
  parameter int DATA_W = 16
) (
  input  logic              bit_clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] par_data,
  output logic              ser_out,
  output logic              word_clk
);

  localparam int RATIO = DATA_W;

  logic              cap_evt;
  logic              load_evt;
  logic [DATA_W-1:0] shadow;

  ser_divider #(.RATIO(RATIO)) u_div (
    .clk      (bit_clk),
    .rst      (rst),
    .word_clk (word_clk),
    .cap_evt  (cap_evt),
    .load_evt (load_evt)
  );

  ser_capture #(.W(DATA_W)) u_cap (
    .clk     (bit_clk),
    .rst     (rst),
    .cap_evt (cap_evt),
    .din     (par_data),
    .shadow  (shadow)
  );

  ser_shifter #(.W(DATA_W)) u_shf (
    .clk      (bit_clk),
    .rst      (rst),
    .load_evt (load_evt),
    .shadow   (shadow),
    .ser_out  (ser_out)
  );

  // R5
  evt_exclusive_chk: assert property (@(negedge bit_clk) disable iff (rst)
    $onehot0({cap_evt, load_evt}));

endmodule

// File: tb/word_serializer_test.sv
`timescale 1ns/1ps
module word_serializer_test;

  localparam int NW = 6;
  localparam logic [15:0] WORDS [NW] = '{16'hA5C3, 16'h0001, 16'h8000,
                                         16'hFFFF, 16'h0000, 16'h1234};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] par_data = 16'h0;
  logic        ser_out;
  logic        word_clk;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  word_serializer uut (
    .bit_clk  (clk),
    .rst      (rst),
    .par_data (par_data),
    .ser_out  (ser_out),
    .word_clk (word_clk)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Expected word clock level after falling edge n counted from release.
  function automatic logic exp_wclk(input int n);
    return (n % 16) < 8;
  endfunction

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic s_hold, w_hold;
    // Reset state (R6)
    repeat (4) @(posedge clk);
    chk("R6 reset ser_out", ser_out, 1'b0);
    chk("R6 reset word_clk", word_clk, 1'b1);

    // Table walk: word k driven at step 16k, replaced by garbage at 16k+12.
    rst = 1'b0;
    par_data = WORDS[0];
    for (int n = 1; n <= 16 * NW + 15; n++) begin
      @(posedge clk);
      if (n < 16) chk("R6 idle before first load", ser_out, 1'b0);
      else chk("R4/R5/R7 serial bit", ser_out, WORDS[(n - 16) / 16][(n - 16) % 16]);
      chk("R1 word_clk phase", word_clk, exp_wclk(n));
      if (n % 16 == 0 && n / 16 < NW) par_data = WORDS[n / 16];
      if (n % 16 == 12 && n / 16 < NW) par_data = ~WORDS[n / 16]; // R3: ignored
      s_hold = ser_out;
      w_hold = word_clk;
      #2.0;
      chk("R2 ser_out held before falling edge", ser_out, s_hold);
      chk("R2 word_clk held before falling edge", word_clk, w_hold);
    end

    // Reset in the middle of a word
    @(posedge clk);
    rst = 1'b1;
    repeat (3) begin
      @(posedge clk);
      chk("R6 mid-stream reset ser_out", ser_out, 1'b0);
      chk("R6 mid-stream reset word_clk", word_clk, 1'b1);
    end

    // Capture edge precision: change just before and just after the capture edge.
    rst = 1'b0;
    par_data = 16'h0F0F;
    for (int m = 1; m <= 47; m++) begin
      @(posedge clk);
      if (m < 16) chk("R6 idle after re-release", ser_out, 1'b0);
      else if (m < 32) chk("R3 late-before-capture value used", ser_out, m == 16 || m == 31);
      else chk("R5/R7 next word after reset", ser_out, 16'hC3A5 >> (m - 32));
      chk("R1 word_clk restarts", word_clk, exp_wclk(m));
      if (m == 7)  par_data = 16'h8001;
      if (m == 8)  par_data = 16'hFFFF; // after capture: no effect
      if (m == 16) par_data = 16'hC3A5;
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule